// File: doc/BRIEF.md
# Predicated scalar ALU lane

This block is one scalar integer lane of a small in-order control processor. Each cycle it may accept one decoded 27-bit slot word. The word names an X source register, a Y operand, a second register field and a 6-bit opcode. The Y operand is either a register or a 32-bit immediate that arrives alongside the slot. The lane computes add, subtract, bitwise, shift, unsigned min/max, carry-out, integer compare and predicate-OR results. It writes the result either to a 32-entry scalar register file or to one of eight predicate bits.

Every operation is gated by a predication header held in the top five bits of the slot. In normal mode the header selects one of eight predicate bits. In rotate mode the same bits form a 4-bit index into a 16-entry predicate ring, and that index is offset by a ring base pointer. A rotate input advances the base pointer, and a separate write port loads ring entries. Operations that check for overflow set a sticky flag, and they still write the wrapped result.

The register file and predicate state sit inside the lane. A load port preloads registers. The write performed by each operation is reported on a result port one clock edge after the operation is presented.

Top module: `pred_scalar_lane`

## Requirements
- R1: After reset, res_valid and ovf_flag are 0, all eight predicate bits and all sixteen ring entries are 1, the ring base is 0, and every register reads 0.
- R2: Slot fields are x0 = bits [4:0], Y = bits [10:5], x1 = bits [15:11] and opcode = bits [21:16]. Y bit 10 set selects op_imm as the Y operand; otherwise register Y[4:0] is used. The X operand is register x0. A register result is written to x0 and appears on res_valid/res_idx/res_data after the next rising edge.
- R3: Opcode 0x0a writes X+Y and 0x0c writes Y−X, both modulo 2^32.
- R4: Opcodes 0x0b (X+Y), 0x0d (Y−X) and 0x31 write the wrapped result and set ovf_flag on signed overflow. ovf_flag then stays 1 until reset.
- R5: Opcodes 0x0e/0x0f/0x10 write X AND/OR/XOR Y. Opcodes 0x1c/0x1d write the unsigned maximum/minimum of X and Y.
- R6: Opcodes 0x17/0x18/0x19 shift X logically left, logically right and arithmetically right by Y[4:0]. Opcode 0x31 shifts X left by Y[4:0] and counts as overflow when shifting the result arithmetically back right does not give X.
- R7: Opcodes 0x1e..0x27 compare X with Y as eq, ne, signed gt, ge, lt, le, then unsigned gt, ge, lt, le. The compare writes predicate x1[2:0] and no register. Opcode 0x28 writes the unsigned carry-out of X+Y (0 or 1) to a register. Opcode 0x29 writes predicate x1[2:0] with predicate x0[2:0] OR predicate Y[2:0].
- R8: With slot bit 26 clear, the operation is enabled by predicate bits[24:22] XOR bit 25.
- R9: With slot bit 26 set, the operation is enabled by ring entry (base + bits[25:22]) mod 16 XOR bit 25. Bit 25 serves as both the index MSB and the inversion.
- R10: A ring_rotate pulse advances the base by one, modulo 16. ring_wr_en writes the ring entry whose physical index is ring_wr_idx. An operation presented in the same cycle as either of these uses the values from before the update.
- R11: An operation that is predicated off writes no register, changes no predicate and leaves ovf_flag unchanged.
- R12: Register 0 always reads as zero. Operations and loads that target it change nothing, and res_valid stays low.
- R13: An opcode outside the supported set has no effect on registers, predicates or ovf_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A slot is presented this cycle |
| op_slot | input | 27 | Decoded slot word |
| op_imm | input | 32 | Immediate used when Y bit 10 is set |
| rf_ld_en | input | 1 | Register preload strobe (an operation write to the same register wins) |
| rf_ld_idx | input | 5 | Register preload index |
| rf_ld_data | input | 32 | Register preload value |
| ring_rotate | input | 1 | Advance the ring base by one |
| ring_wr_en | input | 1 | Ring entry write strobe |
| ring_wr_idx | input | 4 | Physical ring entry to write |
| ring_wr_val | input | 1 | Value written to the ring entry |
| res_valid | output | 1 | A register write happened at the last edge |
| res_idx | output | 5 | Register written |
| res_data | output | 32 | Value written |
| pred_state | output | 8 | Current predicate bits |
| ovf_flag | output | 1 | Sticky signed-overflow flag |

## Verification
The properties take for granted that op_valid, the slot fields and the ring controls are driven to known values from reset onward. They also take for granted that ring_rotate is a single-cycle strobe whose effect is judged one edge later. The stimulus keeps every input at a defined idle value outside the task that drives it. It never loads a register in the same cycle that an operation writes that register, and it applies ring writes and rotations only where an expected ordering has been computed for them. The reference model in the bench derives gating, results and the predicate vector from the written requirements. Each operation's expected item is queued when the operation is driven and compared against the ports at the following falling edge.

// File: rtl/lane_pkg.sv
// Shared definitions for the predicated scalar lane: slot layout and opcodes.
// Assumes a fixed 27-bit slot; only the data width and storage sizes vary.
package lane_pkg;

    typedef struct packed {
        logic       rot;   // [26] rotate-mode select
        logic       inv;   // [25] inversion, and ring index MSB in rotate mode
        logic [2:0] pidx;  // [24:22] predicate index
        logic [5:0] opc;   // [21:16]
        logic [4:0] x1;    // [15:11]
        logic [5:0] y;     // [10:5] bit 5 = immediate select
        logic [4:0] x0;    // [4:0]
    } slot_t;

    typedef enum logic [5:0] {
        OP_ADD  = 6'h0a, OP_ADDV = 6'h0b, OP_SUB  = 6'h0c, OP_SUBV = 6'h0d,
        OP_AND  = 6'h0e, OP_OR   = 6'h0f, OP_XOR  = 6'h10,
        OP_SHL  = 6'h17, OP_LSR  = 6'h18, OP_ASR  = 6'h19,
        OP_UMAX = 6'h1c, OP_UMIN = 6'h1d,
        OP_CEQ  = 6'h1e, OP_CNE  = 6'h1f, OP_SGT  = 6'h20, OP_SGE  = 6'h21,
        OP_SLT  = 6'h22, OP_SLE  = 6'h23, OP_UGT  = 6'h24, OP_UGE  = 6'h25,
        OP_ULT  = 6'h26, OP_ULE  = 6'h27,
        OP_CARRY = 6'h28, OP_POR = 6'h29, OP_ASLV = 6'h31
    } lane_op_e;

    localparam logic [5:0] CMP_FIRST = 6'h1e;
    localparam logic [5:0] CMP_LAST  = 6'h27;

endpackage

// File: rtl/lane_regfile.sv
// Scalar register file with two combinational read ports, one operation write
// port and one preload port. Entry 0 is constant zero. Assumes the operation
// write has priority when both ports target the same entry.
module lane_regfile #(
    parameter  int XLEN = 32,
    parameter  int NREG = 32,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [RIDX-1:0] rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [RIDX-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            ld_en,
    input  logic [RIDX-1:0] ld_idx,
    input  logic [XLEN-1:0] ld_data
);

    logic [XLEN-1:0] mem [NREG];

    // Storage update: reset clears, preload first, operation write last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else begin
            if (ld_en && ld_idx != '0) mem[ld_idx] <= ld_data;
            if (wr_en && wr_idx != '0) mem[wr_idx] <= wr_data;
        end
    end

    // Read ports: index 0 yields zero.
    always_comb begin
        rd_a_data = (rd_a_idx == '0) ? '0 : mem[rd_a_idx];
        rd_b_data = (rd_b_idx == '0) ? '0 : mem[rd_b_idx];
    end

    // R12: entry 0 never holds anything but zero.
    p_zero_reg_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem[0] == '0);

endmodule

// File: rtl/lane_pred.sv
// Predicate state: eight normal predicate bits, a rotating ring with a base
// pointer, and the gate decision for the current slot header. Assumes the
// ring size is a power of two so the base wraps naturally.
module lane_pred #(
    parameter  int NPRED = 8,
    parameter  int RING  = 16,
    localparam int NIW   = $clog2(NPRED),
    localparam int RIW   = $clog2(RING)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_rot,
    input  logic             hdr_inv,
    input  logic [NIW-1:0]   hdr_nidx,
    input  logic [RIW-1:0]   hdr_ridx,
    output logic             gate,
    input  logic             rotate,
    input  logic             ring_we,
    input  logic [RIW-1:0]   ring_widx,
    input  logic             ring_wval,
    input  logic             pw_en,
    input  logic [NIW-1:0]   pw_idx,
    input  logic             pw_val,
    output logic [NPRED-1:0] npred
);

    logic [NPRED-1:0] npred_q, npred_d;
    logic [RING-1:0]  ring_q, ring_d;
    logic [RIW-1:0]   base_q;
    logic [RIW-1:0]   ptr;
    logic             sel;

    // Next state of each normal predicate bit.
    for (genvar g = 0; g < NPRED; g++) begin : g_np
        assign npred_d[g] = (pw_en && pw_idx == NIW'(g)) ? pw_val : npred_q[g];
    end

    // Next state of each ring entry, addressed physically.
    for (genvar g = 0; g < RING; g++) begin : g_ring
        assign ring_d[g] = (ring_we && ring_widx == RIW'(g)) ? ring_wval : ring_q[g];
    end

    // State registers; reset enables everything and zeroes the base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            npred_q <= '1;
            ring_q  <= '1;
            base_q  <= '0;
        end else begin
            npred_q <= npred_d;
            ring_q  <= ring_d;
            if (rotate) base_q <= base_q + 1'b1;
        end
    end

    // Gate: pick the addressed predicate source, then apply inversion.
    always_comb begin
        ptr  = base_q + hdr_ridx;
        sel  = hdr_rot ? ring_q[ptr] : npred_q[hdr_nidx];
        gate = sel ^ hdr_inv;
    end

    assign npred = npred_q;

    // R10: each pulse moves the base by exactly one step, wrapping.
    p_base_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rotate |=> base_q == $past(base_q) + 1'b1);

    // R10: without a pulse the base holds.
    p_base_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rotate |=> $stable(base_q));

endmodule

// File: rtl/lane_alu.sv
// Combinational integer datapath for one slot. Produces the register result,
// the predicate result, a signed-overflow indication and the write kind.
// Assumes XLEN is a power of two so Y's low bits form the shift amount.
module lane_alu #(
    parameter  int XLEN = 32,
    localparam int SHW  = $clog2(XLEN)
) (
    input  logic [5:0]      opc,
    input  logic [XLEN-1:0] xv,
    input  logic [XLEN-1:0] yv,
    input  logic            pa,
    input  logic            pb,
    output logic [XLEN-1:0] res,
    output logic            pbit,
    output logic            ovf,
    output logic            wr_reg,
    output logic            wr_pred,
    output logic            legal
);
    import lane_pkg::*;

    localparam int M = XLEN - 1;

    logic [XLEN:0]   cw;
    logic [XLEN-1:0] sum, diff, shl;
    logic [SHW-1:0]  sh;

    // Shared adders and shifter.
    always_comb begin
        cw   = {1'b0, xv} + {1'b0, yv};
        sum  = cw[XLEN-1:0];
        diff = yv - xv;
        sh   = yv[SHW-1:0];
        shl  = xv << sh;
    end

    // Opcode decode and result selection.
    always_comb begin
        res = '0; pbit = 1'b0; ovf = 1'b0;
        wr_reg = 1'b0; wr_pred = 1'b0; legal = 1'b1;
        case (opc)
            OP_ADD:  begin res = sum;  wr_reg = 1'b1; end
            OP_ADDV: begin
                res = sum; wr_reg = 1'b1;
                ovf = (xv[M] == yv[M]) && (sum[M] != xv[M]);
            end
            OP_SUB:  begin res = diff; wr_reg = 1'b1; end
            OP_SUBV: begin
                res = diff; wr_reg = 1'b1;
                ovf = (yv[M] != xv[M]) && (diff[M] != yv[M]);
            end
            OP_AND:  begin res = xv & yv; wr_reg = 1'b1; end
            OP_OR:   begin res = xv | yv; wr_reg = 1'b1; end
            OP_XOR:  begin res = xv ^ yv; wr_reg = 1'b1; end
            OP_SHL:  begin res = shl;     wr_reg = 1'b1; end
            OP_LSR:  begin res = xv >> sh; wr_reg = 1'b1; end
            OP_ASR:  begin res = $unsigned($signed(xv) >>> sh); wr_reg = 1'b1; end
            OP_UMAX: begin res = (xv > yv) ? xv : yv; wr_reg = 1'b1; end
            OP_UMIN: begin res = (xv < yv) ? xv : yv; wr_reg = 1'b1; end
            OP_CEQ:  begin pbit = (xv == yv); wr_pred = 1'b1; end
            OP_CNE:  begin pbit = (xv != yv); wr_pred = 1'b1; end
            OP_SGT:  begin pbit = ($signed(xv) >  $signed(yv)); wr_pred = 1'b1; end
            OP_SGE:  begin pbit = ($signed(xv) >= $signed(yv)); wr_pred = 1'b1; end
            OP_SLT:  begin pbit = ($signed(xv) <  $signed(yv)); wr_pred = 1'b1; end
            OP_SLE:  begin pbit = ($signed(xv) <= $signed(yv)); wr_pred = 1'b1; end
            OP_UGT:  begin pbit = (xv >  yv); wr_pred = 1'b1; end
            OP_UGE:  begin pbit = (xv >= yv); wr_pred = 1'b1; end
            OP_ULT:  begin pbit = (xv <  yv); wr_pred = 1'b1; end
            OP_ULE:  begin pbit = (xv <= yv); wr_pred = 1'b1; end
            OP_CARRY: begin res = XLEN'(cw[XLEN]); wr_reg = 1'b1; end
            OP_POR:  begin pbit = pa | pb; wr_pred = 1'b1; end
            OP_ASLV: begin
                res = shl; wr_reg = 1'b1;
                ovf = (($signed(shl) >>> sh) != $signed(xv));
            end
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/pred_scalar_lane.sv
// Top of the predicated scalar lane. Decodes the slot, reads operands,
// gates the operation by the predication header, commits register or
// predicate results and keeps the sticky overflow flag. Assumes at most one
// slot per cycle and single-cycle commit.
module pred_scalar_lane #(
    parameter  int XLEN  = 32,
    parameter  int NREG  = 32,
    parameter  int NPRED = 8,
    parameter  int RING  = 16,
    localparam int RIDX  = $clog2(NREG),
    localparam int NIW   = $clog2(NPRED),
    localparam int RIW   = $clog2(RING)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [26:0]      op_slot,
    input  logic [XLEN-1:0]  op_imm,
    input  logic             rf_ld_en,
    input  logic [RIDX-1:0]  rf_ld_idx,
    input  logic [XLEN-1:0]  rf_ld_data,
    input  logic             ring_rotate,
    input  logic             ring_wr_en,
    input  logic [RIW-1:0]   ring_wr_idx,
    input  logic             ring_wr_val,
    output logic             res_valid,
    output logic [RIDX-1:0]  res_idx,
    output logic [XLEN-1:0]  res_data,
    output logic [NPRED-1:0] pred_state,
    output logic             ovf_flag
);
    import lane_pkg::*;

    slot_t           s;
    logic [XLEN-1:0] xv, yreg, yv, alu_res;
    logic            gate, alu_pbit, alu_ovf, alu_wr_reg, alu_wr_pred, alu_legal;
    logic            fire, rwe, pwe;
    logic [NPRED-1:0] npred;
    logic [1:0]      lane_unused;

    assign s           = slot_t'(op_slot);
    assign lane_unused = s.x1[4:3];

    lane_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (RIDX'(s.x0)),
        .rd_a_data (xv),
        .rd_b_idx  (RIDX'(s.y[4:0])),
        .rd_b_data (yreg),
        .wr_en     (rwe),
        .wr_idx    (RIDX'(s.x0)),
        .wr_data   (alu_res),
        .ld_en     (rf_ld_en),
        .ld_idx    (rf_ld_idx),
        .ld_data   (rf_ld_data)
    );

    lane_pred #(.NPRED(NPRED), .RING(RING)) u_pred (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_rot   (s.rot),
        .hdr_inv   (s.inv),
        .hdr_nidx  (NIW'(s.pidx)),
        .hdr_ridx  (RIW'({s.inv, s.pidx})),
        .gate      (gate),
        .rotate    (ring_rotate),
        .ring_we   (ring_wr_en),
        .ring_widx (ring_wr_idx),
        .ring_wval (ring_wr_val),
        .pw_en     (pwe),
        .pw_idx    (NIW'(s.x1[2:0])),
        .pw_val    (alu_pbit),
        .npred     (npred)
    );

    // Y operand: immediate or register.
    assign yv = s.y[5] ? op_imm : yreg;

    lane_alu #(.XLEN(XLEN)) u_alu (
        .opc     (s.opc),
        .xv      (xv),
        .yv      (yv),
        .pa      (npred[NIW'(s.x0[2:0])]),
        .pb      (npred[NIW'(s.y[2:0])]),
        .res     (alu_res),
        .pbit    (alu_pbit),
        .ovf     (alu_ovf),
        .wr_reg  (alu_wr_reg),
        .wr_pred (alu_wr_pred),
        .legal   (alu_legal)
    );

    // Commit enables: valid, gated on and a known opcode.
    always_comb begin
        fire = op_valid && gate && alu_legal;
        rwe  = fire && alu_wr_reg && (s.x0 != 5'd0);
        pwe  = fire && alu_wr_pred;
    end

    // Result reporting register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_idx   <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= rwe;
            if (rwe) begin
                res_idx  <= RIDX'(s.x0);
                res_data <= alu_res;
            end
        end
    end

    // Sticky overflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovf_flag <= 1'b0;
        else if (fire && alu_ovf)   ovf_flag <= 1'b1;
    end

    assign pred_state = npred;

    // R11: a gated-off slot leaves every architectural output untouched.
    p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !gate) |=> (!res_valid && $stable(pred_state) && $stable(ovf_flag)));

    // R4: the overflow flag never falls outside reset.
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R7: compares never report a register write.
    p_cmp_noreg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && s.opc >= CMP_FIRST && s.opc <= CMP_LAST) |=> !res_valid);

    // R13: unknown opcodes change nothing visible.
    p_illegal_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !alu_legal) |=> (!res_valid && $stable(pred_state) && $stable(ovf_flag)));

    // R12: a slot whose destination is register 0 reports no write.
    p_r0_nowrite_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && s.x0 == 5'd0) |=> !res_valid);

endmodule

// File: tb/tb_pred_scalar_lane.sv
// Scoreboard bench: the driver computes the expected item from a reference
// model built from the requirements and queues it; a monitor compares at the
// falling edge after each operation commits.
module tb_pred_scalar_lane;

    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] Y_IMM = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [26:0] op_slot = '0;
    logic [31:0] op_imm = '0;
    logic        rf_ld_en = 1'b0;
    logic [4:0]  rf_ld_idx = '0;
    logic [31:0] rf_ld_data = '0;
    logic        ring_rotate = 1'b0;
    logic        ring_wr_en = 1'b0;
    logic [3:0]  ring_wr_idx = '0;
    logic        ring_wr_val = 1'b0;
    logic        res_valid;
    logic [4:0]  res_idx;
    logic [31:0] res_data;
    logic [7:0]  pred_state;
    logic        ovf_flag;

    pred_scalar_lane dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_slot(op_slot),
        .op_imm(op_imm), .rf_ld_en(rf_ld_en), .rf_ld_idx(rf_ld_idx),
        .rf_ld_data(rf_ld_data), .ring_rotate(ring_rotate),
        .ring_wr_en(ring_wr_en), .ring_wr_idx(ring_wr_idx),
        .ring_wr_val(ring_wr_val), .res_valid(res_valid), .res_idx(res_idx),
        .res_data(res_data), .pred_state(pred_state), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit          rv;
        logic [4:0]  idx;
        logic [31:0] data;
        logic [7:0]  pred;
        bit          ovf;
        string       tag;
    } exp_t;

    exp_t expq[$];
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Reference state
    logic [31:0] m_rf [32];
    logic [7:0]  m_np;
    logic [15:0] m_ring;
    logic [3:0]  m_base;
    bit          m_ovf;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop one expected item per committed operation.
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            chk(res_valid == e.rv, e.tag, "res_valid", 32'(res_valid), 32'(e.rv));
            if (e.rv) begin
                chk(res_idx == e.idx, e.tag, "res_idx", 32'(res_idx), 32'(e.idx));
                chk(res_data == e.data, e.tag, "res_data", res_data, e.data);
            end
            chk(pred_state == e.pred, e.tag, "pred_state", 32'(pred_state), 32'(e.pred));
            chk(ovf_flag == e.ovf, e.tag, "ovf_flag", 32'(ovf_flag), 32'(e.ovf));
        end
    end

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        m_np = 8'hFF; m_ring = 16'hFFFF; m_base = '0; m_ovf = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic load(input logic [4:0] idx, input logic [31:0] val);
        @(negedge clk);
        rf_ld_en = 1'b1; rf_ld_idx = idx; rf_ld_data = val;
        @(posedge clk); #1;
        rf_ld_en = 1'b0;
        if (idx != 0) m_rf[idx] = val;
    endtask

    task automatic ring_ctl(input bit rp, input bit we, input logic [3:0] wi, input bit wv);
        @(negedge clk);
        ring_rotate = rp; ring_wr_en = we; ring_wr_idx = wi; ring_wr_val = wv;
        @(posedge clk); #1;
        ring_rotate = 1'b0; ring_wr_en = 1'b0;
        if (we) m_ring[wi] = wv;
        if (rp) m_base = m_base + 4'd1;
    endtask

    // Full driver: model, queue the expected item, drive one slot.
    task automatic do_op(input logic [5:0] opc, input logic [4:0] x0, input logic [5:0] y,
                         input logic [4:0] x1, input logic [2:0] pn, input bit inv,
                         input bit rot, input logic [31:0] imm, input bit rp,
                         input bit rwe, input logic [3:0] rwi, input bit rwv,
                         input string tag);
        logic [31:0] xv, yv, r;
        logic [32:0] s33;
        logic [63:0] w;
        logic [4:0]  sh;
        logic [3:0]  ri;
        bit g, o, wr, wp, pv;
        exp_t e;
        xv = (x0 == 0) ? 32'd0 : m_rf[x0];
        yv = y[5] ? imm : ((y[4:0] == 0) ? 32'd0 : m_rf[y[4:0]]);
        sh = yv[4:0];
        ri = m_base + {inv, pn};
        g  = rot ? (m_ring[ri] ^ inv) : (m_np[pn] ^ inv);
        r = '0; o = 0; wr = 1; wp = 0; pv = 0;
        case (opc)
            6'h0a: r = xv + yv;
            6'h0b: begin s33 = {xv[31], xv} + {yv[31], yv}; r = s33[31:0]; o = s33[32] != s33[31]; end
            6'h0c: r = yv - xv;
            6'h0d: begin s33 = {yv[31], yv} - {xv[31], xv}; r = s33[31:0]; o = s33[32] != s33[31]; end
            6'h0e: r = xv & yv;
            6'h0f: r = xv | yv;
            6'h10: r = xv ^ yv;
            6'h17: r = xv << sh;
            6'h18: r = xv >> sh;
            6'h19: begin w = {{32{xv[31]}}, xv} >> sh; r = w[31:0]; end
            6'h1c: r = (xv > yv) ? xv : yv;
            6'h1d: r = (xv > yv) ? yv : xv;
            6'h28: begin s33 = {1'b0, xv} + {1'b0, yv}; r = {31'd0, s33[32]}; end
            6'h31: begin
                w = {{32{xv[31]}}, xv} << sh; r = w[31:0];
                o = !((w[63:31] == '0) || (w[63:31] == '1));
            end
            6'h1e, 6'h1f, 6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27: begin
                wr = 0; wp = 1;
                case (opc)
                    6'h1e: pv = xv == yv;
                    6'h1f: pv = xv != yv;
                    6'h20: pv = $signed(xv) >  $signed(yv);
                    6'h21: pv = $signed(xv) >= $signed(yv);
                    6'h22: pv = $signed(xv) <  $signed(yv);
                    6'h23: pv = $signed(xv) <= $signed(yv);
                    6'h24: pv = xv >  yv;
                    6'h25: pv = xv >= yv;
                    6'h26: pv = xv <  yv;
                    default: pv = xv <= yv;
                endcase
            end
            6'h29: begin wr = 0; wp = 1; pv = m_np[x0[2:0]] | m_np[y[2:0]]; end
            default: begin wr = 0; end
        endcase
        if (g) begin
            if (wr && x0 != 0) m_rf[x0] = r;
            if (wp) m_np[x1[2:0]] = pv;
            if (o) m_ovf = 1;
        end
        e.rv = g && wr && (x0 != 0);
        e.idx = x0; e.data = r;
        if (rwe) m_ring[rwi] = rwv;
        if (rp) m_base = m_base + 4'd1;
        e.pred = m_np; e.ovf = m_ovf; e.tag = tag;
        @(negedge clk);
        op_valid = 1'b1; op_slot = {rot, inv, pn, opc, x1, y, x0}; op_imm = imm;
        ring_rotate = rp; ring_wr_en = rwe; ring_wr_idx = rwi; ring_wr_val = rwv;
        @(posedge clk); #1;
        op_valid = 1'b0; ring_rotate = 1'b0; ring_wr_en = 1'b0;
        expq.push_back(e);
    endtask

    task automatic alu(input logic [5:0] opc, input logic [4:0] x0, input logic [5:0] y,
                       input logic [4:0] x1, input logic [31:0] imm, input string tag);
        do_op(opc, x0, y, x1, 3'd0, 0, 0, imm, 0, 0, 4'd0, 0, tag);
    endtask

    task automatic gated(input logic [5:0] opc, input logic [4:0] x0, input logic [31:0] imm,
                         input logic [2:0] pn, input bit inv, input bit rot, input string tag);
        do_op(opc, x0, Y_IMM, 5'd5, pn, inv, rot, imm, 0, 0, 4'd0, 0, tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(res_valid == 0, "R1", "res_valid", 32'(res_valid), 0);
        chk(pred_state == 8'hFF, "R1", "pred_state", 32'(pred_state), 32'hFF);
        chk(ovf_flag == 0, "R1", "ovf_flag", 32'(ovf_flag), 0);
        alu(6'h0a, 5'd5, Y_IMM, 5'd0, 32'd0, "R1");   // r5 reads reset zero

        // R2 / R3: register and immediate Y, add and reverse subtract
        load(5'd1, 32'd5); load(5'd2, 32'd7);
        alu(6'h0a, 5'd1, 6'd2, 5'd0, 32'd0, "R2");
        alu(6'h0c, 5'd2, Y_IMM, 5'd0, 32'd100, "R3");
        alu(6'h0a, 5'd1, Y_IMM, 5'd0, 32'hFFFF_FFFF, "R3");

        // R4: overflow forms and stickiness
        load(5'd3, 32'h7FFF_FFFF);
        alu(6'h0b, 5'd3, Y_IMM, 5'd0, 32'd1, "R4");
        alu(6'h0a, 5'd1, Y_IMM, 5'd0, 32'd1, "R4");
        alu(6'h0b, 5'd1, Y_IMM, 5'd0, 32'd1, "R4");
        do_reset();
        load(5'd4, 32'h8000_0000);
        alu(6'h0d, 5'd4, Y_IMM, 5'd0, 32'd1, "R4");
        do_reset();
        load(5'd4, 32'h0000_0010);
        alu(6'h0d, 5'd4, Y_IMM, 5'd0, 32'd3, "R4");

        // R5: bitwise and unsigned min/max
        load(5'd6, 32'hFFFF_0000); alu(6'h0e, 5'd6, Y_IMM, 5'd0, 32'h00FF_00FF, "R5");
        load(5'd6, 32'hFFFF_0000); alu(6'h0f, 5'd6, Y_IMM, 5'd0, 32'h00FF_00FF, "R5");
        load(5'd6, 32'hFFFF_0000); alu(6'h10, 5'd6, Y_IMM, 5'd0, 32'h00FF_00FF, "R5");
        load(5'd6, 32'hFFFF_0000); alu(6'h1c, 5'd6, Y_IMM, 5'd0, 32'd5, "R5");
        load(5'd6, 32'hFFFF_0000); alu(6'h1d, 5'd6, Y_IMM, 5'd0, 32'd5, "R5");

        // R6: shifts, amount from Y[4:0] only
        load(5'd7, 32'h8000_0000); alu(6'h18, 5'd7, Y_IMM, 5'd0, 32'd36, "R6");
        load(5'd7, 32'h8000_0000); alu(6'h19, 5'd7, Y_IMM, 5'd0, 32'd4, "R6");
        load(5'd7, 32'h0000_0003); alu(6'h17, 5'd7, Y_IMM, 5'd0, 32'd4, "R6");
        load(5'd7, 32'hFFFF_FFFD); alu(6'h31, 5'd7, Y_IMM, 5'd0, 32'd2, "R6");
        load(5'd7, 32'h4000_0000); alu(6'h31, 5'd7, Y_IMM, 5'd0, 32'd1, "R6");
        do_reset();

        // R7: every compare, carry-out, predicate OR
        load(5'd8, 32'hFFFF_FFFF);
        for (int k = 0; k < 10; k++)
            alu(6'h1e + 6'(k), 5'd8, Y_IMM, 5'd3, 32'd1, "R7");
        load(5'd9, 32'hFFFF_FFFF);
        alu(6'h28, 5'd9, Y_IMM, 5'd0, 32'd1, "R7");
        alu(6'h28, 5'd9, Y_IMM, 5'd0, 32'd0, "R7");
        alu(6'h29, 5'd3, 6'd4, 5'd5, 32'd0, "R7");
        alu(6'h29, 5'd3, 6'd3, 5'd6, 32'd0, "R7");

        // R8: normal predication with and without inversion (pred3 is 0 now)
        load(5'd10, 32'd1);
        gated(6'h0a, 5'd10, 32'd1, 3'd3, 0, 0, "R8");
        gated(6'h0a, 5'd10, 32'd1, 3'd3, 1, 0, "R8");
        gated(6'h0a, 5'd10, 32'd1, 3'd2, 0, 0, "R8");

        // R11: gated-off ops leave register, predicate and flag alone
        gated(6'h0a, 5'd10, 32'd100, 3'd3, 0, 0, "R11");
        alu(6'h0a, 5'd10, Y_IMM, 5'd0, 32'd0, "R11");
        load(5'd11, 32'h7FFF_FFFF);
        gated(6'h0b, 5'd11, 32'd1, 3'd3, 0, 0, "R11");
        do_op(6'h1e, 5'd11, Y_IMM, 5'd5, 3'd3, 0, 0, 32'd0, 0, 0, 4'd0, 0, "R11");

        // R9 / R10: rotating ring
        ring_ctl(0, 1, 4'd5, 0);
        gated(6'h0a, 5'd12, 32'd3, 3'd5, 0, 1, "R9");
        ring_ctl(1, 0, 4'd0, 0);
        gated(6'h0a, 5'd12, 32'd3, 3'd4, 0, 1, "R10");
        gated(6'h0a, 5'd12, 32'd3, 3'd5, 0, 1, "R9");
        gated(6'h0a, 5'd12, 32'd3, 3'd5, 1, 1, "R9");
        for (int k = 0; k < 8; k++) ring_ctl(1, 0, 4'd0, 0);
        gated(6'h0a, 5'd12, 32'd3, 3'd4, 1, 1, "R9");
        for (int k = 0; k < 7; k++) ring_ctl(1, 0, 4'd0, 0);
        gated(6'h0a, 5'd12, 32'd3, 3'd5, 0, 1, "R10");
        do_op(6'h0a, 5'd12, Y_IMM, 5'd0, 3'd5, 0, 1, 32'd3, 0, 1, 4'd5, 1, "R10");
        gated(6'h0a, 5'd12, 32'd3, 3'd5, 0, 1, "R10");
        ring_ctl(0, 1, 4'd6, 0);
        do_op(6'h0a, 5'd12, Y_IMM, 5'd0, 3'd5, 0, 1, 32'd3, 1, 0, 4'd0, 0, "R10");
        gated(6'h0a, 5'd12, 32'd3, 3'd5, 0, 1, "R10");

        // R12: register zero
        alu(6'h0a, 5'd0, Y_IMM, 5'd0, 32'd9, "R12");
        load(5'd0, 32'd55);
        load(5'd13, 32'd11);
        alu(6'h0a, 5'd13, 6'd0, 5'd0, 32'd0, "R12");

        // R13: unsupported opcodes
        alu(6'h05, 5'd13, Y_IMM, 5'd3, 32'd4, "R13");
        alu(6'h3f, 5'd13, Y_IMM, 5'd3, 32'd4, "R13");
        alu(6'h0a, 5'd13, Y_IMM, 5'd0, 32'd0, "R13");

        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule